// File: doc/BRIEF.md
# Miss Cost Tracking Register File

This block holds a small set of outstanding cache misses and, for each demand miss, adds up how many processor stall cycles that miss is responsible for. In every clock cycle a live demand entry earns one cycle of cost divided by the number of demand entries live in that cycle. An isolated miss therefore earns a full unit per cycle, and misses that overlap split each cycle evenly among themselves. Prefetch entries occupy a slot but earn no cost and are left out of the divisor.

A new miss enters through a valid/ready port. The slot it lands in is the lowest free index, and that index is reported in the same cycle so the requester can use it later to retire the miss. When the fill returns, the requester pulses `done_valid` with that index. One cycle later the block presents the stored block address and the accumulated cost, reduced to a 3-bit level. Back-pressure exists only on the allocate side: `alloc_ready` falls while every slot is in use. The retire output has no ready and must be taken in the cycle `ret_valid` is high. The done port is a plain control strobe.

Cost is held in unsigned fixed point with 6 fraction bits. The per-cycle share is floor(64/N) sixty-fourths, where N is the live demand count. The accumulator saturates at its top value instead of wrapping.

Top module: `mshr_cost_tracker`

## Requirements
- R1: After reset, no slot is live, `alloc_ready` is 1, `full` is 0 and `ret_valid` is 0.
- R2: While a slot is free, `alloc_idx` shows the lowest-numbered free slot in the same cycle. A request taken while `alloc_valid` and `alloc_ready` are both high fills that slot at the next edge.
- R3: While all slots are live, `full` is 1 and `alloc_ready` is 0. A request presented then changes no slot.
- R4: A done request naming a live slot frees that slot. In the following cycle `ret_valid` is 1 and `ret_addr` shows the address stored at allocation.
- R5: A done request naming a free slot has no effect, and `ret_valid` stays 0 in the following cycle.
- R6: A demand miss that is the only live demand entry earns exactly one cycle of cost for each cycle it is live. This counts the cycle of its done request and excludes the cycle of its allocation.
- R7: With N live demand entries in a cycle, each of them adds floor(64/N)/64 of a cycle. N includes an entry being retired in that cycle and excludes one being allocated.
- R8: A prefetch entry (`alloc_demand` = 0) earns no cost, so its `ret_cost` is 0, and it does not count toward N.
- R9: `ret_cost` is the integer part of the cost divided by 60, so 0 to 59 cycles gives 0, 60 to 119 gives 1, and so on. Any cost of 420 or more gives 7.
- R10: A done request and an accepted allocation for different slots in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A slot is free; the request is taken when both are high |
| alloc_demand | input | 1 | 1 for a demand miss, 0 for a prefetch |
| alloc_addr | input | ADDR_W (32) | Block address of the miss |
| alloc_idx | output | IDX_W (3) | Slot that the current request would fill |
| full | output | 1 | Every slot is live |
| done_valid | input | 1 | Retire request for a returned fill |
| done_idx | input | IDX_W (3) | Slot to retire |
| ret_valid | output | 1 | One-cycle pulse carrying a retired miss |
| ret_addr | output | ADDR_W (32) | Block address of the retired miss |
| ret_cost | output | Q_W (3) | Quantized cost of the retired miss |

## Verification
Retirement of one slot and acceptance of a new miss into another slot can fall in the same clock edge. The bench forces this directly, once while the file is full (the allocation must be refused) and once with a single slot free (both must happen). Its random phase also produces the pairing often. Each pairing is judged against a cycle model. That model takes the slot choice from the state before the edge, counts the retiring entry in the divisor and leaves the new one out, and then compares the freed slot's address and cost level and the index handed to the next request.

// File: rtl/mshr_cost_pkg.sv
package mshr_cost_pkg;

  // Fixed-point share of one cycle split across n live demand misses.
  function automatic int unsigned share_of(input int unsigned n, input int unsigned frac_w);
    if (n == 0) return 0;
    return (32'd1 << frac_w) / n;
  endfunction

endpackage

// File: rtl/mshr_free_picker.sv
module mshr_free_picker #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     live,
  output logic             any_free,
  output logic [IDX_W-1:0] pick
);
  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!live[i]) begin
        any_free = 1'b1;
        pick     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_share_unit.sv
module mshr_share_unit #(
  parameter int N      = 8,
  parameter int FRAC_W = 6,
  parameter int COST_W = 16
) (
  input  logic [N-1:0]      demand_live,
  output logic [COST_W-1:0] share
);
  import mshr_cost_pkg::*;
  localparam int CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CNT_W'(demand_live[i]);
  end

  logic [COST_W-1:0] table_q [N+1];
  generate
    for (genvar k = 0; k <= N; k++) begin : g_tab
      assign table_q[k] = COST_W'(share_of(k, FRAC_W));
    end
  endgenerate

  always_comb begin
    share = '0;
    for (int k = 1; k <= N; k++) begin
      if (32'(cnt) == k) share = table_q[k];
    end
  end
endmodule

// File: rtl/mshr_cost_quantizer.sv
module mshr_cost_quantizer #(
  parameter int COST_W     = 16,
  parameter int FRAC_W     = 6,
  parameter int BIN_CYCLES = 60,
  parameter int Q_W        = 3
) (
  input  logic [COST_W-1:0] cost,
  output logic [Q_W-1:0]    level
);
  localparam int INT_W  = COST_W - FRAC_W;
  localparam int LEVELS = 1 << Q_W;

  logic [INT_W-1:0]  whole;
  logic [LEVELS-1:1] over;

  assign whole = cost[COST_W-1:FRAC_W];

  generate
    for (genvar b = 1; b < LEVELS; b++) begin : g_bin
      localparam int EDGE = BIN_CYCLES * b;
      if (EDGE >= (1 << INT_W)) begin : g_unreach
        assign over[b] = 1'b0;
      end else begin : g_cmp
        assign over[b] = (whole >= INT_W'(EDGE));
      end
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int b = 1; b < LEVELS; b++) level = level + Q_W'(over[b]);
  end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int ADDR_W = 32,
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              alloc_demand,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              retire_en,
  input  logic [COST_W-1:0] share,
  output logic              live,
  output logic              demand,
  output logic [ADDR_W-1:0] addr,
  output logic [COST_W-1:0] cost_now
);
  logic [COST_W-1:0] cost_q;
  logic [COST_W:0]   sum;
  logic [COST_W-1:0] inc;

  assign inc      = (live && demand) ? share : '0;
  assign sum      = {1'b0, cost_q} + {1'b0, inc};
  assign cost_now = sum[COST_W] ? '1 : sum[COST_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      demand <= 1'b0;
      addr   <= '0;
      cost_q <= '0;
    end else if (alloc_en) begin
      live   <= 1'b1;
      demand <= alloc_demand;
      addr   <= alloc_addr;
      cost_q <= '0;
    end else if (retire_en) begin
      live   <= 1'b0;
      cost_q <= '0;
    end else if (live && demand) begin
      cost_q <= cost_now;
    end
  end

  // R8: a prefetch slot never holds cost
  a_r8_prefetch_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !demand) |-> (cost_q == '0));

  // R6: a lone or shared demand slot grows while it stays live
  a_r6_cost_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (live && demand && !alloc_en && !retire_en && share != '0 && cost_q != '1)
      |=> (cost_q > $past(cost_q)));
endmodule

// File: rtl/mshr_cost_tracker.sv
module mshr_cost_tracker #(
  parameter int N          = 8,
  parameter int ADDR_W     = 32,
  parameter int FRAC_W     = 6,
  parameter int INT_W      = 10,
  parameter int BIN_CYCLES = 60,
  parameter int Q_W        = 3,
  parameter int IDX_W      = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_demand,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  output logic              ret_valid,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [Q_W-1:0]    ret_cost
);
  localparam int COST_W = INT_W + FRAC_W;

  logic [N-1:0]      live_q, demand_q;
  logic [ADDR_W-1:0] addr_q   [N];
  logic [COST_W-1:0] cost_now [N];
  logic [COST_W-1:0] share;
  logic              any_free, alloc_fire, done_ok;
  logic [ADDR_W-1:0] done_addr;
  logic [COST_W-1:0] done_cost;
  logic [Q_W-1:0]    done_level;

  mshr_free_picker #(.N(N), .IDX_W(IDX_W)) i_picker (
    .live(live_q), .any_free(any_free), .pick(alloc_idx));

  mshr_share_unit #(.N(N), .FRAC_W(FRAC_W), .COST_W(COST_W)) i_share (
    .demand_live(live_q & demand_q), .share(share));

  assign alloc_ready = any_free;
  assign full        = !any_free;
  assign alloc_fire  = alloc_valid && any_free;

  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      mshr_entry #(.ADDR_W(ADDR_W), .COST_W(COST_W)) i_entry (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_fire && (alloc_idx == IDX_W'(i))),
        .alloc_demand(alloc_demand), .alloc_addr(alloc_addr),
        .retire_en(done_valid && (done_idx == IDX_W'(i))),
        .share(share),
        .live(live_q[i]), .demand(demand_q[i]),
        .addr(addr_q[i]), .cost_now(cost_now[i]));
    end
  endgenerate

  always_comb begin
    done_ok   = 1'b0;
    done_addr = '0;
    done_cost = '0;
    for (int i = 0; i < N; i++) begin
      if (done_idx == IDX_W'(i)) begin
        done_ok   = done_valid && live_q[i];
        done_addr = addr_q[i];
        done_cost = cost_now[i];
      end
    end
  end

  mshr_cost_quantizer #(.COST_W(COST_W), .FRAC_W(FRAC_W),
    .BIN_CYCLES(BIN_CYCLES), .Q_W(Q_W)) i_quant (
    .cost(done_cost), .level(done_level));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_addr  <= '0;
      ret_cost  <= '0;
    end else begin
      ret_valid <= done_ok;
      if (done_ok) begin
        ret_addr <= done_addr;
        ret_cost <= done_level;
      end
    end
  end

  // R2: the offered slot is free
  a_r2_pick_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> live_q[$past(alloc_idx)]);

  // R3: a full file with no retire keeps its slots
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !done_ok) |=> $stable(live_q));

  // R4: retire of a live slot reports its address next cycle
  a_r4_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (ret_valid && ret_addr == $past(done_addr)));

  // R5: retire of a free slot is dropped
  a_r5_ignore_free: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ok) |=> !ret_valid);

  // R9: large costs land in the top level
  a_r9_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && 32'(done_cost[COST_W-1:FRAC_W]) >= BIN_CYCLES * ((1 << Q_W) - 1))
      |=> (ret_cost == '1));
endmodule

// File: tb/test_mshr_cost_tracker.sv
module test_mshr_cost_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, alloc_demand = 1'b0, done_valid = 1'b0;
  logic [31:0] alloc_addr = '0;
  logic [2:0]  done_idx = '0;
  logic        alloc_ready, full, ret_valid;
  logic [2:0]  alloc_idx, ret_cost;
  logic [31:0] ret_addr;

  int n_chk = 0, n_bad = 0;
  bit          m_live [8];
  bit          m_dem  [8];
  logic [31:0] m_addr [8];
  int unsigned m_cost [8];

  always #2 clk = ~clk;

  mshr_cost_tracker i_mshr_cost_tracker (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_demand(alloc_demand), .alloc_addr(alloc_addr), .alloc_idx(alloc_idx),
    .full(full), .done_valid(done_valid), .done_idx(done_idx),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_cost(ret_cost));

  function automatic int unsigned level_of(input int unsigned c);
    int unsigned q = (c / 64) / 60;
    return (q > 7) ? 7 : q;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit av, input bit dem, input logic [31:0] ad,
                      input bit dv, input int di, input string tag);
    bit mf = 1; int pk = 0; int n = 0; int unsigned inc;
    bit erv = 0; logic [31:0] ea = '0; int unsigned eq = 0;
    alloc_valid = av; alloc_demand = dem; alloc_addr = ad;
    done_valid = dv; done_idx = di[2:0];
    #1;
    for (int i = 7; i >= 0; i--) if (!m_live[i]) begin mf = 0; pk = i; end
    chk("R3 ready", alloc_ready, !mf);
    chk("R3 full", full, mf);
    if (!mf) chk("R2 idx", alloc_idx, pk);
    for (int i = 0; i < 8; i++) if (m_live[i] && m_dem[i]) n++;
    inc = (n > 0) ? 64 / n : 0;
    for (int i = 0; i < 8; i++)
      if (m_live[i] && m_dem[i]) m_cost[i] = (m_cost[i] + inc > 65535) ? 65535 : m_cost[i] + inc;
    if (dv && m_live[di]) begin
      erv = 1; ea = m_addr[di]; eq = level_of(m_cost[di]); m_live[di] = 0;
    end
    if (av && !mf) begin
      m_live[pk] = 1; m_dem[pk] = dem; m_addr[pk] = ad; m_cost[pk] = 0;
    end
    @(posedge clk); @(negedge clk);
    chk(dv ? "R4/R5 ret_valid" : "R4 ret_valid", ret_valid, erv);
    if (erv) begin
      chk("R4 addr", ret_addr, ea);
      chk(tag, ret_cost, eq);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, "R7");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_live[i] = 0; m_dem[i] = 0; m_addr[i] = 0; m_cost[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", alloc_ready, 1); chk("R1 full", full, 0); chk("R1 ret", ret_valid, 0);

    // R6: isolated demand miss held 130 cycles -> level 2
    step(1, 1, 32'hA000, 0, 0, "R6");
    idle(129);
    step(0, 0, 0, 1, 0, "R6 cost level 2");
    chk("R6 direct", ret_cost, 2);

    // R8: prefetch beside demand; prefetch cost 0, demand keeps full share
    step(1, 1, 32'hB000, 0, 0, "R8");
    step(1, 0, 32'hB040, 0, 0, "R8");
    idle(70);
    step(0, 0, 0, 1, 1, "R8 prefetch cost");
    chk("R8 direct", ret_cost, 0);
    step(0, 0, 0, 1, 0, "R8 demand unshared");
    chk("R8 demand level", ret_cost, 1);

    // R9: long isolated miss saturates level
    step(1, 1, 32'hC000, 0, 0, "R9");
    idle(450);
    step(0, 0, 0, 1, 0, "R9 top level");
    chk("R9 direct", ret_cost, 7);

    // R7: two demand misses share; 240 cycles at half share -> 120 -> level 2
    step(1, 1, 32'hD000, 0, 0, "R7");
    step(1, 1, 32'hD040, 0, 0, "R7");
    idle(238);
    step(0, 0, 0, 1, 0, "R7 shared cost");
    step(0, 0, 0, 1, 1, "R7 shared cost");

    // R3: fill all slots, then a refused request
    for (int i = 0; i < 8; i++) step(1, 1, 32'hE000 + i * 64, 0, 0, "R3");
    step(1, 1, 32'hDEAD, 0, 0, "R3");
    // R10: retire while full -> alloc refused; then retire+alloc together
    step(1, 1, 32'hF000, 1, 3, "R10 full pair");
    step(1, 1, 32'hF040, 1, 5, "R10 pair");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, i, "R10 drain");

    // R5: retire of free slot
    step(0, 0, 0, 1, 5, "R5");
    chk("R5 no ret", ret_valid, 0);

    // random mix
    for (int t = 0; t < 3000; t++) begin
      bit av = ($urandom % 3) != 0;
      bit dm = ($urandom % 4) != 0;
      bit dv = ($urandom % 10) == 0;
      step(av, dm, $urandom, dv, $urandom % 8, "R7 random cost");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule